// File: doc/BRIEF.md
# Bus Clock Prescaler with Deferred Ratio Update

This block turns a free-running system bus clock into a slower peripheral-bus timing reference. A small encoded setting chooses either pass-through (no division) or a power-of-two division by 2, 4, 8 or 16. The block produces two things: a divided clock level with a 50 percent duty cycle, and a one-cycle enable that marks, in system-clock terms, the last cycle of every divided period. Logic on the peripheral side can run on the system clock and qualify its updates with the enable.

A new setting is loaded by pulsing a write strobe together with the code. The code is held as a pending request. It replaces the running ratio only at the next boundary of a divided period, so the divided clock never shows a shortened half-period. A sequencer with three named states runs the block. `ST_PASS` is the undivided mode. `ST_HIGH` covers the first half of a divided period. `ST_LOW` covers the second half. The transitions are:

- PASS-hold (no request, or a request that is also undivided).
- PASS-to-HIGH (a divide request is applied).
- HIGH-to-LOW (the first half is complete).
- LOW-to-HIGH (the period ends and the ratio is kept or replaced by another divide ratio).
- LOW-to-PASS (the period ends and an undivided request is applied).

Choosing a ratio that keeps the peripheral domain within its frequency limit is left to the software that writes the code.

Top module: `bus_clk_prescaler`

## Requirements
- R1: While reset is asserted and right after it is released, the block is in undivided mode with no request pending: `div_en` = 1 and `div_clk` = 1.
- R2: Any setting whose top bit is 0 (codes 000, 001, 010, 011) selects undivided mode, in which `div_en` is 1 on every system cycle and `div_clk` stays at 1.
- R3: Setting 100 divides by 2, 101 by 4, 110 by 8 and 111 by 16. In other words the ratio N is 2 to the power (low two bits + 1). `div_en` is 1 in exactly one of every N system cycles.
- R4: For N > 1, `div_clk` is 1 during the first N/2 cycles of each divided period and 0 during the last N/2.
- R5: `div_en` is 1 exactly in the last system cycle of each divided period, which is the cycle just before `div_clk` rises.
- R6: A code captured on a clock edge where `code_wr` is 1 takes effect at the first period-ending edge strictly after the write edge. That edge is the one closing a cycle with `div_en` = 1. The delay is therefore 1 to 16 system cycles.
- R7: A write that lands on a period-ending edge does not apply on that edge. The running ratio completes one more full period first.
- R8: A second write made while a request is still pending replaces it. Only the latest code is applied.
- R9: Changes on `code_sel` while `code_wr` is 0 have no effect on the outputs.
- R10: Every period under a newly applied divide ratio starts from its first half, with `div_clk` = 1 in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_sel | input | SEL_W (3) | Encoded prescaler setting |
| code_wr | input | 1 | Write strobe; captures `code_sel` on the rising edge |
| div_clk | output | 1 | Divided clock level, 50 % duty when dividing |
| div_en | output | 1 | One-cycle enable on the last cycle of each divided period |

## Verification
The bench builds the block with the default 3-bit setting, so all eight codes exist and the largest ratio is 16. This makes the full 1-to-16-cycle update window reachable. It sweeps every ordered pair of old and new codes, and for each pair it places the write at every one of 16 phase offsets within the old period. That covers writes at, just after and just before a period boundary for each ratio. Directed phases then add boundary-edge writes, overriding double writes and strobe-less code changes. An arithmetic model of period position and pending state checks both outputs on every cycle.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } bcp_state_e;

endpackage

// File: rtl/bcp_decode.sv
// Splits a setting into its divide flag and the last count of a half period.
module bcp_decode #(
    parameter int SEL_W  = 3,
    parameter int HALF_W = 3
) (
    input  logic [SEL_W-1:0]  sel,
    output logic              divide,
    output logic [HALF_W-1:0] half_last
);
    localparam int EXP_W = SEL_W - 1;

    logic [EXP_W-1:0] exp_m1;

    assign divide = sel[SEL_W-1];
    assign exp_m1 = sel[EXP_W-1:0];

    // half length = 2**exp_m1, so its last count has exp_m1 low ones
    always_comb begin
        for (int i = 0; i < HALF_W; i++) begin
            half_last[i] = divide && (i < int'(exp_m1));
        end
    end
endmodule

// File: rtl/bcp_pending.sv
// Holds a requested setting until the sequencer applies it.
module bcp_pending #(
    parameter int SEL_W   = 3,
    parameter int MAX_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] code_in,
    input  logic             apply,
    output logic             pend_valid,
    output logic [SEL_W-1:0] pend_code
);
    localparam int WAIT_W = $clog2(MAX_DIV) + 1;

    logic [WAIT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_code  <= '0;
        end else if (wr) begin
            pend_valid <= 1'b1;
            pend_code  <= code_in;
        end else if (apply) begin
            pend_valid <= 1'b0;
        end
    end

    // age of the outstanding request, used only by the bound check
    always_ff @(posedge clk) begin
        if (!rst_n || wr) begin
            wait_cnt <= '0;
        end else if (pend_valid && !apply && (wait_cnt != {WAIT_W{1'b1}})) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    p_apply_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (int'(wait_cnt) < MAX_DIV));

    p_latest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pend_valid && (pend_code == $past(code_in))));

    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !apply) |=> ($stable(pend_code) && $stable(pend_valid)));
endmodule

// File: rtl/bcp_fsm.sv
// Sequencer: undivided mode, first half and second half of a divided period.
module bcp_fsm
    import bcp_pkg::*;
#(
    parameter int HALF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              pend_valid,
    input  logic              pend_divide,
    input  logic [HALF_W-1:0] pend_half_last,
    output logic              apply,
    output logic              div_clk,
    output logic              div_en
);
    bcp_state_e        state, state_nxt;
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] act_half_last;
    logic              half_done;
    logic              period_end;

    assign half_done  = (cnt == act_half_last);
    assign period_end = (state == ST_PASS) || ((state == ST_LOW) && half_done);
    // a write on the boundary edge defers the request to the next boundary
    assign apply      = period_end && pend_valid && !wr;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PASS: state_nxt = (apply && pend_divide) ? ST_HIGH : ST_PASS;
            ST_HIGH: state_nxt = half_done ? ST_LOW : ST_HIGH;
            ST_LOW: begin
                if (half_done) begin
                    state_nxt = (apply && !pend_divide) ? ST_PASS : ST_HIGH;
                end
            end
            default: state_nxt = ST_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PASS;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt           <= '0;
            act_half_last <= '0;
        end else begin
            if ((state == ST_PASS) || half_done) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (apply) begin
                act_half_last <= pend_divide ? pend_half_last : '0;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_PASS: begin
                div_clk = 1'b1;
                div_en  = 1'b1;
            end
            ST_HIGH: begin
                div_clk = 1'b1;
                div_en  = 1'b0;
            end
            ST_LOW: begin
                div_clk = 1'b0;
                div_en  = half_done;
            end
            default: begin
                div_clk = 1'b1;
                div_en  = 1'b1;
            end
        endcase
    end

    p_pass_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (div_en && div_clk));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_half_last);

    p_half_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_PASS) && (cnt != '0)) |-> $stable(div_clk));

    p_en_before_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |=> div_clk);

    p_rise_after_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |-> $past(div_en));

    p_new_from_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && pend_divide) |=> ((state == ST_HIGH) && (cnt == '0)));
endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] code_sel,
    input  logic             code_wr,
    output logic             div_clk,
    output logic             div_en
);
    localparam int EXP_W   = SEL_W - 1;
    localparam int MAX_EXP = 2 ** EXP_W;
    localparam int MAX_DIV = 2 ** MAX_EXP;
    localparam int HALF_W  = (MAX_EXP > 1) ? (MAX_EXP - 1) : 1;

    logic             pend_valid;
    logic [SEL_W-1:0] pend_code;
    logic             pend_divide;
    logic [HALF_W-1:0] pend_half_last;
    logic             apply;

    bcp_pending #(
        .SEL_W   (SEL_W),
        .MAX_DIV (MAX_DIV)
    ) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (code_wr),
        .code_in    (code_sel),
        .apply      (apply),
        .pend_valid (pend_valid),
        .pend_code  (pend_code)
    );

    bcp_decode #(
        .SEL_W  (SEL_W),
        .HALF_W (HALF_W)
    ) u_decode (
        .sel       (pend_code),
        .divide    (pend_divide),
        .half_last (pend_half_last)
    );

    bcp_fsm #(
        .HALF_W (HALF_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr             (code_wr),
        .pend_valid     (pend_valid),
        .pend_divide    (pend_divide),
        .pend_half_last (pend_half_last),
        .apply          (apply),
        .div_clk        (div_clk),
        .div_en         (div_en)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (div_en && div_clk && !pend_valid));
endmodule

// File: tb/bus_clk_prescaler_bench.sv
module bus_clk_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] code_sel = 3'b000;
    logic       code_wr = 1'b0;
    logic       div_clk;
    logic       div_en;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    // model of the requirements
    int  m_n = 1;
    int  m_pos = 0;
    int  p_n = 1;
    bit  m_pend = 0;
    bit  m_fresh = 0;
    logic prev_clk = 1'b1;
    logic prev_en = 1'b1;

    always #10 clk = ~clk;

    bus_clk_prescaler u_bus_clk_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_sel (code_sel),
        .code_wr  (code_wr),
        .div_clk  (div_clk),
        .div_en   (div_en)
    );

    function automatic int ratio_of(logic [2:0] c);
        return c[2] ? (1 << (int'(c[1:0]) + 1)) : 1;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b (ratio %0d pos %0d)", tag, act, exp, m_n, m_pos);
        end
    endtask

    task automatic check_outputs(string ph);
        logic e_en, e_clk;
        e_en  = (m_pos == m_n - 1);
        e_clk = (m_n == 1) ? 1'b1 : logic'(m_pos < m_n / 2);
        chk($sformatf("%s %s en", ph, (m_n == 1) ? "R2" : "R3"), div_en, e_en);
        chk($sformatf("%s %s clk", ph, (m_n == 1) ? "R2" : "R4"), div_clk, e_clk);
        if (m_fresh) chk("R10 first cycle high", div_clk, 1'b1);
        if (div_clk === 1'b1 && prev_clk === 1'b0) chk("R5 enable before rise", prev_en, 1'b1);
        prev_clk = div_clk;
        prev_en  = div_en;
    endtask

    task automatic model_edge(bit wr, logic [2:0] c);
        bit boundary;
        boundary = (m_pos == m_n - 1);
        m_fresh = 0;
        if (boundary && m_pend && !wr) begin
            m_n = p_n;
            m_pend = 0;
            m_pos = 0;
            m_fresh = (m_n > 1);
        end else if (boundary) begin
            m_pos = 0;
        end else begin
            m_pos++;
        end
        if (wr) begin
            p_n = ratio_of(c);
            m_pend = 1;
        end
    endtask

    task automatic step(bit wr, logic [2:0] c, string ph);
        @(negedge clk);
        check_outputs(ph);
        code_wr  = wr;
        code_sel = c;
        @(posedge clk);
        model_edge(wr, c);
    endtask

    task automatic idle(int n, string ph);
        for (int i = 0; i < n; i++) step(1'b0, code_sel, ph);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset en", div_en, 1'b1);
        chk("R1 reset clk", div_clk, 1'b1);
        rst_n = 1'b1;
        @(posedge clk);
        idle(4, "R1");

        // R6: every old/new pair, write at every offset in the old period
        for (int o = 0; o < 8; o++) begin
            for (int nw = 0; nw < 8; nw++) begin
                for (int off = 0; off < 16; off++) begin
                    step(1'b1, 3'(o), "R6 set");
                    idle(18, "R6 settle");
                    idle(off, "R6 offset");
                    step(1'b1, 3'(nw), "R6 write");
                    idle(18, "R6 after");
                end
            end
        end

        // R7: write exactly on a period-ending edge
        for (int o = 4; o < 8; o++) begin
            step(1'b1, 3'(o), "R7 set");
            idle(18, "R7 settle");
            while (m_pos != m_n - 1) step(1'b0, code_sel, "R7 align");
            step(1'b1, 3'b101, "R7 write");
            idle(20, "R7 after");
        end

        // R8: overriding writes, latest wins
        step(1'b1, 3'b111, "R8 set");
        idle(20, "R8 settle");
        idle(3, "R8");
        step(1'b1, 3'b100, "R8 first");
        step(1'b1, 3'b000, "R8 second");
        idle(3, "R8");
        step(1'b1, 3'b110, "R8 third");
        idle(40, "R8 after");

        // R9: code changes without the strobe
        for (int c = 0; c < 8; c++) step(1'b0, 3'(c), "R9");
        idle(20, "R9");
        step(1'b1, 3'b000, "R9 set");
        idle(20, "R9 settle");
        for (int c = 7; c >= 0; c--) begin
            step(1'b0, 3'(c), "R9");
            step(1'b0, 3'(c), "R9");
        end
        idle(4, "R9");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule